// File: doc/BRIEF.md
# I2C Bus Event Monitor

This block listens to an I2C bus without ever driving it. Both lines arrive already synchronized to the system clock. The block turns the activity on the lines into a stream of single-cycle events. Each event reports one of three bus conditions or one classified 9-bit frame: a first START, a repeated START, or a STOP on one hand, and an address or data byte on the other. Each event carries a command code, a byte value and an acknowledge flag. A companion output presents the raw 8 bits of every frame, without the acknowledge bit, in the same cycle as the frame event.

Inside, a three-state tracker moves through three states:

- `ST_WAIT_START` waits for a START.
- `ST_ADDR` collects the address frame.
- `ST_DATA` collects any number of data frames.

The transitions between these states are:

- `WAIT_START -> ADDR` on a START.
- `ADDR -> DATA` when the ninth bit of the address frame arrives.
- `DATA -> DATA` on every completed data frame.
- `DATA -> ADDR` on a repeated START.
- `DATA -> WAIT_START` on a STOP.

The direction bit of the most recent address frame selects between read and write codes for every data frame that follows it. A START or a STOP clears that direction. Events appear on the outputs one clock after the sample that caused them.

Top module: `i2c_event_monitor`

## Requirements
- R1: A fall of `sda_in` while `scl_in` is high, seen in `ST_WAIT_START`, produces an event with code 1 (first START) and moves the tracker to `ST_ADDR`.
- R2: A START seen in `ST_DATA` produces code 2 (repeated START) and returns the tracker to `ST_ADDR`. A START line condition seen in `ST_ADDR` is ignored and does not disturb the frame being collected.
- R3: A rise of `sda_in` while `scl_in` is high, seen in `ST_DATA`, produces code 7 (STOP) and returns the tracker to `ST_WAIT_START`. The next START after it is again reported as code 1.
- R4: Bits are taken on each rise of `scl_in`, MSB first, nine per frame. `evt_nack` equals the ninth bit: 0 means ACK and 1 means NACK.
- R5: An address frame, which is the first frame after a START, reports `evt_byte` = {1'b0, frame bits 7..1}. It reports code 3 (address read) when frame bit 0 is 1 and code 4 (address write) when frame bit 0 is 0.
- R6: Every later frame reports its 8 bits in `evt_byte`. The code is 5 (data read) when the latest address direction was read and 6 (data write) otherwise, for any number of consecutive frames.
- R7: `raw_valid` pulses in the same cycle as every address or data event, with `raw_frame` holding the first 8 bits of the frame. It never pulses for START or STOP events.
- R8: Events with codes 1, 2 and 7 carry `evt_byte` = 0 and `evt_nack` = 0.
- R9: In `ST_WAIT_START`, SCL pulses and STOP conditions produce no event. Bits clocked in that state do not enter the next frame.
- R10: In `ST_DATA`, a sample in which `scl_in` rises and `sda_in` falls together is taken as a data bit, not as a repeated START.
- R11: The first sample after reset only records the line levels. Lines held at SCL=1, SDA=0 through reset produce no START.
- R12: While `rst_n` is low, every output is 0. `evt_valid` and `raw_valid` are one-cycle strobes, issued one clock after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronized serial clock line |
| sda_in | input | 1 | Synchronized serial data line |
| evt_valid | output | 1 | Event strobe |
| evt_cmd | output | 3 | Event code: 1 START, 2 repeated START, 3 address read, 4 address write, 5 data read, 6 data write, 7 STOP |
| evt_byte | output | DATA_W (8) | Address (zero-extended) or data byte |
| evt_nack | output | 1 | Acknowledge bit of the frame, 1 = NACK |
| raw_valid | output | 1 | Raw frame strobe |
| raw_frame | output | DATA_W (8) | First 8 bits of the frame, acknowledge bit removed |

## Verification
The hardest cases to reach from the ports are samples in which two line conditions coincide. One is a START line pattern that arrives while the address frame is only partly collected. The other is a sample where SCL rises and SDA falls together during a data frame. The stimulus builds both cases on purpose. It raises SCL over a high SDA and then drops SDA before SCL falls, inside the address frame. It also changes both lines in one step at the start of a data byte. In each case the scoreboard expects a frame event with the bit values as sampled, and no START event at all. A reset taken with the lines at SCL=1, SDA=0 also checks that the first sample is not read as an edge.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef enum logic [2:0] {
        CMD_NONE    = 3'd0,
        CMD_START   = 3'd1,
        CMD_RSTART  = 3'd2,
        CMD_ADDR_RD = 3'd3,
        CMD_ADDR_WR = 3'd4,
        CMD_DATA_RD = 3'd5,
        CMD_DATA_WR = 3'd6,
        CMD_STOP    = 3'd7
    } evt_cmd_e;

    typedef enum logic [1:0] {
        ST_WAIT_START = 2'd0,
        ST_ADDR       = 2'd1,
        ST_DATA       = 2'd2
    } trk_state_e;

endpackage

// File: rtl/i2cmon_line_edges.sv
module i2cmon_line_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic start_cond,
    output logic stop_cond
);
    logic scl_prev, sda_prev, primed;

    // Previous line levels; nothing is reported until one sample is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
            primed   <= 1'b0;
        end else begin
            scl_prev <= scl;
            sda_prev <= sda;
            primed   <= 1'b1;
        end
    end

    always_comb begin
        scl_rise   = primed && !scl_prev && scl;
        start_cond = primed && sda_prev && !sda && scl;
        stop_cond  = primed && !sda_prev && sda && scl;
    end
endmodule

// File: rtl/i2cmon_frame_shift.sv
module i2cmon_frame_shift #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic              last_bit,
    output logic [DATA_W-1:0] data_bits
);
    localparam int CNT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q     <= '0;
            data_bits <= '0;
        end else if (shift_en) begin
            if (cnt_q == LAST) begin
                cnt_q     <= '0;
                data_bits <= '0;
            end else begin
                cnt_q     <= cnt_q + 1'b1;
                data_bits <= {data_bits[DATA_W-2:0], bit_in};
            end
        end
    end

    assign last_bit = (cnt_q == LAST);
endmodule

// File: rtl/i2c_event_monitor.sv
module i2c_event_monitor
    import i2cmon_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              evt_valid,
    output logic [2:0]        evt_cmd,
    output logic [DATA_W-1:0] evt_byte,
    output logic              evt_nack,
    output logic              raw_valid,
    output logic [DATA_W-1:0] raw_frame
);
    localparam int ADDR_W = DATA_W - 1;

    trk_state_e        state_q, state_d;
    logic              rep_q, rep_d, rd_q, rd_d;
    logic              scl_rise, start_cond, stop_cond;
    logic              clr, shift, last_bit, done;
    logic [DATA_W-1:0] data_bits;

    logic              ev_d, raw_d, nack_d;
    evt_cmd_e          cmd_d;
    logic [DATA_W-1:0] byte_d, rawf_d;

    i2cmon_line_edges u_edges (
        .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
        .scl_rise(scl_rise), .start_cond(start_cond), .stop_cond(stop_cond)
    );

    i2cmon_frame_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(clr), .shift_en(shift),
        .bit_in(sda_in), .last_bit(last_bit), .data_bits(data_bits)
    );

    assign done = shift && last_bit;

    always_comb begin
        state_d = state_q;
        rep_d   = rep_q;
        rd_d    = rd_q;
        clr     = 1'b0;
        shift   = 1'b0;
        ev_d    = 1'b0;
        raw_d   = 1'b0;
        nack_d  = 1'b0;
        cmd_d   = CMD_NONE;
        byte_d  = '0;
        rawf_d  = '0;
        unique case (state_q)
            ST_WAIT_START: begin
                if (start_cond) begin
                    clr     = 1'b1;
                    ev_d    = 1'b1;
                    cmd_d   = rep_q ? CMD_RSTART : CMD_START;
                    rep_d   = 1'b1;
                    rd_d    = 1'b0;
                    state_d = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (scl_rise) begin
                    shift = 1'b1;
                    if (done) begin
                        ev_d    = 1'b1;
                        raw_d   = 1'b1;
                        nack_d  = sda_in;
                        rawf_d  = data_bits;
                        rd_d    = data_bits[0];
                        byte_d  = {1'b0, data_bits[DATA_W-1:1]};
                        cmd_d   = data_bits[0] ? CMD_ADDR_RD : CMD_ADDR_WR;
                        state_d = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (scl_rise) begin
                    shift = 1'b1;
                    if (done) begin
                        ev_d   = 1'b1;
                        raw_d  = 1'b1;
                        nack_d = sda_in;
                        rawf_d = data_bits;
                        byte_d = data_bits;
                        cmd_d  = rd_q ? CMD_DATA_RD : CMD_DATA_WR;
                    end
                end else if (start_cond) begin
                    clr     = 1'b1;
                    ev_d    = 1'b1;
                    cmd_d   = rep_q ? CMD_RSTART : CMD_START;
                    rep_d   = 1'b1;
                    rd_d    = 1'b0;
                    state_d = ST_ADDR;
                end else if (stop_cond) begin
                    ev_d    = 1'b1;
                    cmd_d   = CMD_STOP;
                    rep_d   = 1'b0;
                    rd_d    = 1'b0;
                    state_d = ST_WAIT_START;
                end
            end
            default: state_d = ST_WAIT_START;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_START;
            rep_q   <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            rep_q   <= rep_d;
            rd_q    <= rd_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_cmd   <= 3'd0;
            evt_byte  <= '0;
            evt_nack  <= 1'b0;
            raw_valid <= 1'b0;
            raw_frame <= '0;
        end else begin
            evt_valid <= ev_d;
            evt_cmd   <= cmd_d;
            evt_byte  <= byte_d;
            evt_nack  <= nack_d;
            raw_valid <= raw_d;
            raw_frame <= rawf_d;
        end
    end

    logic unused_addr_w;
    assign unused_addr_w = (ADDR_W == 0);
endmodule

// File: rtl/i2cmon_checker.sv
module i2cmon_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_in,
    input logic              evt_valid,
    input logic [2:0]        evt_cmd,
    input logic [DATA_W-1:0] evt_byte,
    input logic              evt_nack,
    input logic              raw_valid,
    input logic [DATA_W-1:0] raw_frame
);
    logic is_ctrl, is_addr, is_data;
    assign is_ctrl = evt_valid && (evt_cmd == 3'd1 || evt_cmd == 3'd2 || evt_cmd == 3'd7);
    assign is_addr = evt_valid && (evt_cmd == 3'd3 || evt_cmd == 3'd4);
    assign is_data = evt_valid && (evt_cmd == 3'd5 || evt_cmd == 3'd6);

    // R1 and R2: a START-type event follows a sample with SCL high and SDA low.
    a_r1_start_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_cmd == 3'd1 || evt_cmd == 3'd2)) |-> ($past(scl_in) && !$past(sda_in)));

    // R3: a STOP event follows a sample with both lines high.
    a_r3_stop_lines: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_cmd == 3'd7) |-> ($past(scl_in) && $past(sda_in)));

    // R5: the address field is zero-extended and matches the raw frame.
    a_r5_addr_field: assert property (@(posedge clk) disable iff (!rst_n)
        is_addr |-> (!evt_byte[DATA_W-1] && evt_byte[DATA_W-2:0] == raw_frame[DATA_W-1:1]));

    // R6: a data byte equals the raw frame.
    a_r6_data_field: assert property (@(posedge clk) disable iff (!rst_n)
        is_data |-> (evt_byte == raw_frame));

    // R7: the raw strobe pairs only with frame events.
    a_r7_raw_pairing: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |-> (is_addr || is_data));

    // R8: condition events carry no payload.
    a_r8_ctrl_payload: assert property (@(posedge clk) disable iff (!rst_n)
        is_ctrl |-> (evt_byte == '0 && !evt_nack && !raw_valid));

    // R12: no strobe without a valid code.
    a_r12_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_cmd != 3'd0));
endmodule

bind i2c_event_monitor i2cmon_checker #(.DATA_W(DATA_W)) u_i2cmon_checker (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_byte(evt_byte),
    .evt_nack(evt_nack), .raw_valid(raw_valid), .raw_frame(raw_frame)
);

// File: tb/test_i2c_event_monitor.sv
module test_i2c_event_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 3;

    typedef struct packed {
        logic [2:0] cmd;
        logic [7:0] byte_v;
        logic       nack;
        logic       raw_v;
        logic [7:0] raw;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b0;
    logic       evt_valid, evt_nack, raw_valid;
    logic [2:0] evt_cmd;
    logic [7:0] evt_byte, raw_frame;

    int checks = 0;
    int fails = 0;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_event_monitor #(.DATA_W(8)) i_i2c_event_monitor (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .evt_valid(evt_valid), .evt_cmd(evt_cmd), .evt_byte(evt_byte),
        .evt_nack(evt_nack), .raw_valid(raw_valid), .raw_frame(raw_frame)
    );

    task automatic drive(input logic c, input logic d);
        scl = c;
        sda = d;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic push_ctrl(input logic [2:0] c);
        expq.push_back('{cmd: c, byte_v: 8'h00, nack: 1'b0, raw_v: 1'b0, raw: 8'h00});
    endtask

    task automatic push_frame(input logic [2:0] c, input logic [7:0] b,
                              input logic n, input logic [7:0] r);
        expq.push_back('{cmd: c, byte_v: b, nack: n, raw_v: 1'b1, raw: r});
    endtask

    task automatic send_start();
        drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);
    endtask

    task automatic send_stop();
        drive(0, 0); drive(1, 0); drive(1, 1);
    endtask

    task automatic send_bit(input logic b);
        drive(0, b); drive(1, b); drive(0, b);
    endtask

    task automatic send_frame(input logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(ack);
    endtask

    // Monitor: every strobe is compared with the head of the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && (evt_valid || raw_valid)) begin
                checks++;
                if (expq.size() == 0) begin
                    fails++;
                    $display("FAIL R9/R10 unexpected event: cmd=%0d byte=%h nack=%b raw_v=%b, expected none",
                             evt_cmd, evt_byte, evt_nack, raw_valid);
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    if (!evt_valid || evt_cmd !== e.cmd || evt_byte !== e.byte_v ||
                        evt_nack !== e.nack || raw_valid !== e.raw_v ||
                        (e.raw_v && raw_frame !== e.raw)) begin
                        fails++;
                        $display("FAIL R1-7 event mismatch: got v=%b cmd=%0d byte=%h nack=%b rv=%b raw=%h, expected cmd=%0d byte=%h nack=%b rv=%b raw=%h",
                                 evt_valid, evt_cmd, evt_byte, evt_nack, raw_valid, raw_frame,
                                 e.cmd, e.byte_v, e.nack, e.raw_v, e.raw);
                    end
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R11: lines at SCL=1, SDA=0 through reset
        repeat (4) @(negedge clk);
        checks++; // R12: outputs low in reset
        if (evt_valid !== 1'b0 || raw_valid !== 1'b0 || evt_cmd !== 3'd0 ||
            evt_byte !== 8'h00 || raw_frame !== 8'h00 || evt_nack !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset outputs: v=%b rv=%b cmd=%0d, expected all 0",
                     evt_valid, raw_valid, evt_cmd);
        end
        rst_n = 1'b1;
        repeat (HOLD) @(negedge clk);   // R11: no START expected from the first sample

        // R9: STOP condition and clocked bits while waiting for START
        drive(1, 1);
        drive(0, 1);
        send_frame(8'hC3, 1'b1);
        drive(1, 1);

        // R1 R4 R5 R6: write transfer, ACK then NACK
        push_ctrl(3'd1);
        push_frame(3'd4, 8'h50, 1'b0, 8'hA0);
        push_frame(3'd6, 8'h3C, 1'b0, 8'h3C);
        push_frame(3'd6, 8'hFF, 1'b1, 8'hFF);
        send_start();
        send_frame(8'hA0, 1'b0);
        send_frame(8'h3C, 1'b0);
        send_frame(8'hFF, 1'b1);

        // R2 R5 R6: repeated START switches to read
        push_ctrl(3'd2);
        push_frame(3'd3, 8'h50, 1'b0, 8'hA1);
        push_frame(3'd5, 8'h96, 1'b1, 8'h96);
        push_ctrl(3'd7);                 // R3
        send_start();
        send_frame(8'hA1, 1'b0);
        send_frame(8'h96, 1'b1);
        send_stop();

        // R3: START after STOP is a first START again
        // R2: START line pattern inside the address frame is ignored
        push_ctrl(3'd1);
        push_frame(3'd3, 8'h55, 1'b0, 8'hAB);
        send_start();
        drive(0, 1); drive(1, 1); drive(1, 0); drive(0, 0);   // bit 1, then SDA falls with SCL high
        for (int i = 6; i >= 0; i--) send_bit(8'hAB >> i);
        send_bit(1'b0);

        // R10: SCL rise and SDA fall in one sample are a data bit
        push_frame(3'd5, 8'h7F, 1'b0, 8'h7F);
        drive(0, 1); drive(1, 0); drive(0, 0);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        send_bit(1'b0);
        push_ctrl(3'd7);
        send_stop();

        // R6 R7: run of back-to-back write data frames
        push_ctrl(3'd1);
        push_frame(3'd4, 8'h12, 1'b1, 8'h24);
        send_start();
        send_frame(8'h24, 1'b1);
        for (int k = 0; k < 4; k++) begin
            logic [7:0] v;
            v = 8'(k * 8'h11 + 8'h03);
            push_frame(3'd6, v, k[0], v);
            send_frame(v, k[0]);
        end
        push_ctrl(3'd7);
        send_stop();

        repeat (10) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            fails++;
            $display("FAIL R1-7 missing events: %0d outstanding, expected 0", expq.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule